// File: doc/BRIEF.md
# High-Speed Port Status and Ownership Register

This block holds the status and control word for one root port of a high-speed host controller whose physical port is shared with full/low-speed companion controllers. It decides which controller owns the port from a global configured flag and a per-port owner field, runs the timed bus-reset sequence that is the only way the port becomes enabled, drives resume signalling on request, and blanks its high-speed fields whenever port power is off or the companion owns the port.

Software reaches the word through a plain 32-bit register port: a write strobe with write data and a combinational read value. The port side supplies connect and high-speed detection inputs and a resume-detected pulse. The block returns an ownership indication, a lock that keeps companion controllers from altering the port while the high-speed controller owns it, and the drive requests for bus reset and resume. No data stream passes through the block, so every pin is a plain level or strobe with no back-pressure.

Field layout of the word: bit 0 connect status (read only), bit 2 port enable, bit 4 force resume, bit 5 port reset, bit 8 port power, bit 12 owner (1 = companion, 0 = high-speed controller). Other bits read 0 and ignore writes.

Top module: `hsport_reg`

## Requirements
- R1: After reset the word reads 0x0000_1000 (owner bit 12 = 1, power off), port_to_comp is 1 and comp_lock, bus_reset_drv and resume_drv are 0.
- R2: On the first clock at which cfg_flag is 1 after having been 0, the owner bit is forced to 0 in the next cycle, regardless of any write in that cycle.
- R3: While cfg_flag is 0 the owner bit is 1 and software writes to bit 12 have no effect.
- R4: While cfg_flag is 1 and has been 1 for at least one clock, a write to bit 12 sets the owner to the written value from the next cycle.
- R5: comp_lock is 1 exactly when the high-speed controller owns the port (owner 0), and port_to_comp mirrors the owner bit.
- R6: A write with bit 5 = 1 while powered, owned and not in reset starts a bus reset: bit 5 reads 1 and bus_reset_drv is 1 for exactly RST_CYCLES cycles, starting the cycle after the write.
- R7: In the cycle after bus reset ends, port enable (bit 2) is 1 only if dev_connect and dev_hispeed are both 1; otherwise it stays 0.
- R8: A software write of 1 to bit 2 never sets port enable.
- R9: A write with bit 2 = 0 clears port enable from the next cycle, and dev_connect going to 0 clears it one cycle later.
- R10: A write of 1 to bit 4 sets force resume and drives resume_drv from the next cycle; a write of 0 clears it; a resume_detect pulse sets bit 4.
- R11: While power (bit 8) is 0, bits 0, 2, 4 and 5 read 0, and enable and resume are cleared so they stay 0 after power returns.
- R12: While the owner bit is 1, bits 0, 2, 4 and 5 read 0, bus_reset_drv and resume_drv are 0, and a running bus reset is aborted without enabling the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read value |
| cfg_flag | input | 1 | Global configured flag |
| dev_connect | input | 1 | Device present on the port |
| dev_hispeed | input | 1 | Device detected as high-speed during reset |
| resume_detect | input | 1 | Resume signalling seen on the port |
| port_to_comp | output | 1 | 1 when a companion controller owns the port |
| comp_lock | output | 1 | 1 when companions must not modify the port |
| bus_reset_drv | output | 1 | Drive bus reset on the port |
| resume_drv | output | 1 | Drive resume (K-state) on the port |

## Verification
The hardest situation to reach is a handoff to the companion while a bus reset is still counting, since it needs the configured flag raised, ownership taken, a device connected and a reset started before the handoff write lands. The stimulus raises the flag, starts a reset, waits a few cycles inside the reset window, then writes the owner bit to 1 and afterwards back to 0, checking that the reset was aborted and enable never set. A separate sequence turns power off with enable and resume set to show they stay cleared when power comes back.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned B_CONN  = 0;
  localparam int unsigned B_EN    = 2;
  localparam int unsigned B_RES   = 4;
  localparam int unsigned B_RST   = 5;
  localparam int unsigned B_PWR   = 8;
  localparam int unsigned B_OWN   = 12;
endpackage

// File: rtl/hsp_owner.sv
module hsp_owner (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_flag,
  input  logic wr_en,
  input  logic wr_owner,
  output logic owner
);
  logic cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner <= 1'b1;
      cfg_q <= 1'b0;
    end else begin
      cfg_q <= cfg_flag;
      if (!cfg_flag)      owner <= 1'b1;
      else if (!cfg_q)    owner <= 1'b0;
      else if (wr_en)     owner <= wr_owner;
    end
  end

  // R2: rising configured flag hands the port to the high-speed controller
  p_cfg_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_flag && !cfg_q) |=> !owner);

  // R3: configured flag low keeps the port with the companion
  p_cfg_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_flag |=> owner);
endmodule

// File: rtl/hsp_rst_seq.sv
module hsp_rst_seq #(
  parameter int unsigned RST_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic active,
  output logic done
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (abort) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= LOAD;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign done = active && (cnt == '0) && !abort;

  // R6: an accepted start puts the port into reset next cycle
  p_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |=> active);
endmodule

// File: rtl/hsp_state.sv
module hsp_state
  import hsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              owner,
  input  logic              dev_connect,
  input  logic              dev_hispeed,
  input  logic              resume_detect,
  input  logic              rst_start,
  input  logic              rst_done,
  output logic              pwr,
  output logic              enable,
  output logic              force_res
);
  logic pwr_off_now;
  assign pwr_off_now = !pwr || (wr_en && !wr_data[B_PWR]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr       <= 1'b0;
      enable    <= 1'b0;
      force_res <= 1'b0;
    end else begin
      if (wr_en) pwr <= wr_data[B_PWR];

      if (pwr_off_now || owner || !dev_connect || rst_start)
        enable <= 1'b0;
      else if (rst_done)
        enable <= dev_hispeed;
      else if (wr_en && !wr_data[B_EN])
        enable <= 1'b0;

      if (pwr_off_now || owner)
        force_res <= 1'b0;
      else
        force_res <= (wr_en ? wr_data[B_RES] : force_res) | resume_detect;
    end
  end

  // R8: enable only rises as the outcome of a completed bus reset
  p_en_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> $past(rst_done));

  // R11: no enable survives a powered-off cycle
  p_pwr_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr |=> !enable);
endmodule

// File: rtl/hsport_reg.sv
module hsport_reg
  import hsp_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [WORD_W-1:0] reg_wr_data,
  output logic [WORD_W-1:0] reg_rd_data,
  input  logic              cfg_flag,
  input  logic              dev_connect,
  input  logic              dev_hispeed,
  input  logic              resume_detect,
  output logic              port_to_comp,
  output logic              comp_lock,
  output logic              bus_reset_drv,
  output logic              resume_drv
);
  logic owner, pwr, enable, force_res;
  logic rst_active, rst_done, rst_start, rst_abort, hs_live;

  hsp_owner u_owner (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_flag (cfg_flag),
    .wr_en    (reg_wr_en),
    .wr_owner (reg_wr_data[B_OWN]),
    .owner    (owner)
  );

  assign rst_start = reg_wr_en && reg_wr_data[B_RST] && reg_wr_data[B_PWR]
                   && pwr && !owner && !rst_active;
  assign rst_abort = !pwr || owner;

  hsp_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (rst_start),
    .abort  (rst_abort),
    .active (rst_active),
    .done   (rst_done)
  );

  hsp_state u_state (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (reg_wr_en),
    .wr_data       (reg_wr_data),
    .owner         (owner),
    .dev_connect   (dev_connect),
    .dev_hispeed   (dev_hispeed),
    .resume_detect (resume_detect),
    .rst_start     (rst_start),
    .rst_done      (rst_done),
    .pwr           (pwr),
    .enable        (enable),
    .force_res     (force_res)
  );

  assign hs_live = pwr && !owner;

  always_comb begin
    reg_rd_data         = '0;
    reg_rd_data[B_OWN]  = owner;
    reg_rd_data[B_PWR]  = pwr;
    reg_rd_data[B_CONN] = hs_live && dev_connect;
    reg_rd_data[B_EN]   = hs_live && enable;
    reg_rd_data[B_RES]  = hs_live && force_res;
    reg_rd_data[B_RST]  = hs_live && rst_active;
  end

  assign port_to_comp  = owner;
  assign comp_lock     = !owner;
  assign bus_reset_drv = hs_live && rst_active;
  assign resume_drv    = hs_live && force_res;

  // R6: a reset on the wire always follows a software reset request
  p_rst_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_reset_drv) |-> $past(reg_wr_en && reg_wr_data[B_RST]));

  // R10: detected resume while live shows up in the force-resume field
  p_res_det_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_detect && hs_live && !(reg_wr_en && (!reg_wr_data[B_PWR] || reg_wr_data[B_OWN])))
      |=> (force_res || owner));
endmodule

// File: tb/sim_hsport_reg.sv
module sim_hsport_reg;
  localparam int unsigned RC = 6;
  localparam logic [31:0] F_CONN = 32'h1, F_EN = 32'h4, F_RES = 32'h10,
                          F_RST = 32'h20, F_PWR = 32'h100, F_OWN = 32'h1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic cfg = 1'b0, conn = 1'b0, hs = 1'b0, rdet = 1'b0;
  logic to_comp, lock, brst, rdrv;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hsport_reg #(.RST_CYCLES(RC)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wr_data(wr_data),
    .reg_rd_data(rd_data), .cfg_flag(cfg), .dev_connect(conn),
    .dev_hispeed(hs), .resume_detect(rdet), .port_to_comp(to_comp),
    .comp_lock(lock), .bus_reset_drv(brst), .resume_drv(rdrv)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic run_reset();
    wr(F_PWR | F_RST);
    repeat (RC) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 word", rd_data, 32'h0000_1000);
    chk("R1 outs", {28'd0, to_comp, lock, brst, rdrv}, 32'h8);
  endtask

  task automatic t_cfg_low();
    wr(F_PWR);
    chk("R3 owner held", rd_data & (F_OWN | F_PWR), F_OWN | F_PWR);
    chk("R3 lock", {31'd0, lock}, 32'd0);
  endtask

  task automatic t_cfg_rise();
    @(negedge clk); cfg = 1'b1;
    @(negedge clk);
    chk("R2 owner cleared", rd_data & F_OWN, 32'd0);
    chk("R5 lock on", {30'd0, lock, to_comp}, 32'h2);
  endtask

  task automatic t_owner_wr();
    wr(F_PWR | F_OWN);
    chk("R4 owner set", rd_data & F_OWN, F_OWN);
    chk("R5 lock off", {30'd0, lock, to_comp}, 32'h1);
    wr(F_PWR);
    chk("R4 owner back", rd_data & F_OWN, 32'd0);
  endtask

  task automatic t_en_w1();
    @(negedge clk); conn = 1'b1; hs = 1'b1;
    wr(F_PWR | F_EN);
    chk("R8 enable stays 0", rd_data & F_EN, 32'd0);
  endtask

  task automatic t_reset_seq();
    wr(F_PWR | F_RST);
    for (int i = 0; i < int'(RC); i++) begin
      chk("R6 in reset", {rd_data & F_RST} | {31'd0, brst}, F_RST | 32'h1);
      @(negedge clk);
    end
    chk("R6 reset over", {rd_data & F_RST} | {31'd0, brst}, 32'd0);
    chk("R7 enabled hs", rd_data & F_EN, F_EN);
  endtask

  task automatic t_en_w0();
    wr(F_PWR);
    chk("R9 write0 clears", rd_data & F_EN, 32'd0);
    run_reset();
    chk("R9 re-enabled", rd_data & F_EN, F_EN);
    @(negedge clk); conn = 1'b0;
    @(negedge clk);
    chk("R9 disconnect clears", rd_data & (F_EN | F_CONN), 32'd0);
    conn = 1'b1;
  endtask

  task automatic t_fs();
    @(negedge clk); hs = 1'b0;
    run_reset();
    chk("R7 full-speed not enabled", rd_data & F_EN, 32'd0);
    hs = 1'b1;
  endtask

  task automatic t_resume();
    wr(F_PWR | F_RES);
    chk("R10 force on", (rd_data & F_RES) | {31'd0, rdrv}, F_RES | 32'h1);
    wr(F_PWR);
    chk("R10 force off", (rd_data & F_RES) | {31'd0, rdrv}, 32'd0);
    @(negedge clk); rdet = 1'b1;
    @(negedge clk); rdet = 1'b0;
    chk("R10 detect sets", rd_data & F_RES, F_RES);
    wr(F_PWR);
  endtask

  task automatic t_power();
    run_reset();
    wr(F_PWR | F_EN | F_RES);
    chk("R11 pre enable+res", rd_data & (F_EN | F_RES), F_EN | F_RES);
    wr(32'd0);
    chk("R11 blanked", rd_data, 32'd0);
    chk("R11 no drive", {30'd0, brst, rdrv}, 32'd0);
    wr(F_PWR | F_EN | F_RES);
    @(negedge clk);
    chk("R11 stays cleared", rd_data & (F_EN | F_RES), 32'd0);
  endtask

  task automatic t_handoff();
    run_reset();
    wr(F_PWR | F_RST);
    repeat (2) @(negedge clk);
    wr(F_PWR | F_OWN);
    chk("R12 blank fields", rd_data & (F_EN | F_RST | F_RES | F_CONN), 32'd0);
    chk("R12 outs", {29'd0, to_comp, brst, rdrv}, 32'h4);
    wr(F_PWR);
    repeat (RC + 2) @(negedge clk);
    chk("R12 reset aborted", rd_data & (F_EN | F_RST), 32'd0);
    @(negedge clk); cfg = 1'b0;
    @(negedge clk);
    chk("R3 cfg drop returns", rd_data & F_OWN, F_OWN);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg_low();
    t_cfg_rise();
    t_owner_wr();
    t_en_w1();
    t_reset_seq();
    t_en_w0();
    t_fs();
    t_resume();
    t_power();
    t_handoff();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule